// File: doc/BRIEF.md
# YUV 4:2:2 Video Output Formatter

This block turns a 27 MHz clock into a complete digital video raster for an interlaced display. It can produce either a 625-line/50 Hz or a 525-line/60 Hz raster. It counts clocks along each line and lines down each frame. From those counts it produces an active-low composite sync, a horizontal active qualifier and a vertical blanking flag. It also drives the 4:2:2 sample stream, in one of two bus formats that can be chosen at run time.

In the dual-bus format, luma and chroma each travel on their own 8-bit bus. Each sample is held for two clocks, so both buses run at 13.5 MHz. A qualifier strobe marks the first clock of every sample. In the single-bus format, one 8-bit bus carries Cb, Y, Cr, Y at the full 27 MHz. Four-byte timing reference codes are placed just before and just after the active samples.

A rectangular viewport is set in units of pixel pairs and active lines. Inside it, a pixel source supplies one pair of pixels (Y0, Y1, Cb, Cr) per ready/valid handshake. Active area outside the viewport carries a programmable border colour. Blanking carries black.

Top module: `vid_fmt422`

## Requirements
- R1: A line lasts LINE_625 clocks (625-line standard) or LINE_525 clocks (525-line standard). `csync_n` is low for the first HSW clocks of every line.
- R2: `href` rises HS_625 or HS_525 clocks after `csync_n` falls. It stays high for 2*ACT_PIX clocks on lines outside vertical blanking, and is low at all other times.
- R3: A frame has two fields. In the 625-line standard they are FA_625 and FB_625 lines long; in the 525-line standard, FA_525 and FB_525. `vsync` is high on the first VB_625 or VB_525 lines of each field.
- R4: With `mode8`=0, each pixel pair occupies four clocks. `y_out` carries Y0 for two clocks and then Y1 for two clocks. `uv_out` carries Cb and then Cr over the same clocks. `cref` is high on the first clock of each two-clock sample, which lies an even number of clocks after the `href` rise.
- R5: With `mode8`=1, `y_out` carries Cb, Y0, Cr, Y1 on successive clocks of each pair, and `uv_out` is held at 0.
- R6: With `mode8`=1, the four clocks before the first active sample carry FF, 00, 00, XY (start code, H=0). The four clocks after the last active sample carry the same pattern with H=1 (end code). The XY byte is {1, F, V, H, V^H, F^H, F^V, F^V^H}, where F is 1 in the second field and V is 1 during vertical blanking.
- R7: Outside the active area, and outside the timing codes, luma is 16 and both chroma values are 128.
- R8: `pix_ready` is high on the clock before each pixel pair whose position lies inside the viewport. The viewport spans pairs `vp_x` to `vp_x+vp_w-1` and active lines `vp_y` to `vp_y+vp_h-1`. Active pixels outside the viewport carry the border colour.
- R9: If `pix_valid` is low while `pix_ready` is high, that pair is sent in the border colour.
- R10: A change of standard or bus format takes effect on the next clock. If the line count already lies beyond the new line length, the next clock starts a new line.
- R11: During reset, the line and frame counts are zero and the held pair is black. The outputs therefore show sync low, `href` low and `vsync` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| std625 | input | 1 | 1 = 625-line raster, 0 = 525-line raster |
| mode8 | input | 1 | 1 = single-bus multiplex, 0 = dual-bus output |
| vp_x | input | XW | Viewport first pixel pair |
| vp_w | input | XW | Viewport width in pixel pairs |
| vp_y | input | YW | Viewport first active line |
| vp_h | input | YW | Viewport height in lines |
| bord_y | input | 8 | Border luma |
| bord_u | input | 8 | Border Cb |
| bord_v | input | 8 | Border Cr |
| pix_ready | output | 1 | Next pair is taken at the coming clock edge |
| pix_valid | input | 1 | Source offers a pair |
| pix_y0 | input | 8 | First luma of pair |
| pix_y1 | input | 8 | Second luma of pair |
| pix_u | input | 8 | Pair Cb |
| pix_v | input | 8 | Pair Cr |
| csync_n | output | 1 | Composite sync, active low |
| href | output | 1 | Active-line qualifier |
| vsync | output | 1 | Vertical blanking flag |
| cref | output | 1 | 13.5 MHz sample qualifier |
| y_out | output | 8 | Luma bus, or multiplexed bus in single-bus mode |
| uv_out | output | 8 | Chroma bus |

## Verification
The bench checks every output on every clock, so a faulty count or a wrong held pair shows up within a clock of when it matters. A line counter that is off by one moves `csync_n` or `href` during the first line after reset. A frame counter that is off moves `vsync` within one line time. A wrong field flag corrupts the XY byte at the next timing code. A sample phase that slips shows up as swapped Y0/Y1 or Cb/Cr inside the first viewport pair.

// File: rtl/vid_fmt422.sv
module vid_fmt422 #(
  parameter int ACT_PIX  = 720,
  parameter int HSW      = 128,
  parameter int LINE_625 = 1728,
  parameter int LINE_525 = 1716,
  parameter int HS_625   = 264,
  parameter int HS_525   = 244,
  parameter int FA_625   = 312,
  parameter int FB_625   = 313,
  parameter int VB_625   = 24,
  parameter int FA_525   = 262,
  parameter int FB_525   = 263,
  parameter int VB_525   = 22,
  parameter int XW       = 9,
  parameter int YW       = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          std625,
  input  logic          mode8,
  input  logic [XW-1:0] vp_x,
  input  logic [XW-1:0] vp_w,
  input  logic [YW-1:0] vp_y,
  input  logic [YW-1:0] vp_h,
  input  logic [7:0]    bord_y,
  input  logic [7:0]    bord_u,
  input  logic [7:0]    bord_v,
  output logic          pix_ready,
  input  logic          pix_valid,
  input  logic [7:0]    pix_y0,
  input  logic [7:0]    pix_y1,
  input  logic [7:0]    pix_u,
  input  logic [7:0]    pix_v,
  output logic          csync_n,
  output logic          href,
  output logic          vsync,
  output logic          cref,
  output logic [7:0]    y_out,
  output logic [7:0]    uv_out
);
  localparam int HW = $clog2(LINE_625 + LINE_525);
  localparam int VW = $clog2(FA_625 + FB_625 + FA_525 + FB_525);
  localparam int A2 = 2 * ACT_PIX;

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic [7:0] py0, py1, pu, pv;

  int lin, fa, ftot, vb, hs, h, v, lf, al, d, nd;
  logic fld, vbl, act, vline, inwin, sav, eav;
  logic [1:0] ph;
  logic [7:0] xy, cy0, cy1, cu, cv;

  always_comb begin
    lin  = std625 ? LINE_625 : LINE_525;
    fa   = std625 ? FA_625 : FA_525;
    ftot = std625 ? FA_625 + FB_625 : FA_525 + FB_525;
    vb   = std625 ? VB_625 : VB_525;
    hs   = std625 ? HS_625 : HS_525;
    h    = int'(hcnt);
    v    = int'(vcnt);
    fld  = v >= fa;
    lf   = fld ? v - fa : v;
    vbl  = lf < vb;
    al   = lf - vb;
    d    = h - hs;
    nd   = d + 1;
    ph   = d[1:0];
    act  = d >= 0 && d < A2;
    vline = !vbl && al >= int'(vp_y) && al < int'(vp_y) + int'(vp_h);
    inwin = act && vline && d / 4 >= int'(vp_x) && d / 4 < int'(vp_x) + int'(vp_w);
    pix_ready = nd >= 0 && nd < A2 && nd[1:0] == 2'd0 && vline &&
                nd / 4 >= int'(vp_x) && nd / 4 < int'(vp_x) + int'(vp_w);
    sav = d >= -4 && d < 0;
    eav = d >= A2 && d < A2 + 4;
    xy  = {1'b1, fld, vbl, eav, vbl ^ eav, fld ^ eav, fld ^ vbl, fld ^ vbl ^ eav};
    if (inwin) begin
      cy0 = py0; cy1 = py1; cu = pu; cv = pv;
    end else if (act && !vbl) begin
      cy0 = bord_y; cy1 = bord_y; cu = bord_u; cv = bord_v;
    end else begin
      cy0 = 8'd16; cy1 = 8'd16; cu = 8'd128; cv = 8'd128;
    end
  end

  assign csync_n = !(h < HSW);
  assign href    = act && !vbl;
  assign vsync   = vbl;
  assign cref    = !ph[0];

  always_comb begin
    if (mode8) begin
      uv_out = 8'd0;
      if (sav || eav)
        case (ph)
          2'd0: y_out = 8'hFF;
          2'd1, 2'd2: y_out = 8'h00;
          default: y_out = xy;
        endcase
      else
        case (ph)
          2'd0: y_out = cu;
          2'd1: y_out = cy0;
          2'd2: y_out = cv;
          default: y_out = cy1;
        endcase
    end else begin
      y_out  = ph[1] ? cy1 : cy0;
      uv_out = ph[1] ? cv : cu;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
      py0 <= 8'd16; py1 <= 8'd16; pu <= 8'd128; pv <= 8'd128;
    end else begin
      if (h >= lin - 1) begin
        hcnt <= '0;
        vcnt <= (v >= ftot - 1) ? '0 : vcnt + 1'b1;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
      if (pix_ready) begin
        py0 <= pix_valid ? pix_y0 : bord_y;
        py1 <= pix_valid ? pix_y1 : bord_y;
        pu  <= pix_valid ? pix_u  : bord_u;
        pv  <= pix_valid ? pix_v  : bord_v;
      end
    end
  end

  // R1
  hcnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt != '0 |-> int'(hcnt) == int'($past(hcnt)) + 1);
  // R2
  sync_href_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !csync_n |-> !href);
  // R8
  rdy_vbl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> !vsync);
  // R9
  take_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready && pix_valid |=> py0 == $past(pix_y0) && pv == $past(pix_v));
  // R6
  sav_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(href) && mode8 && $past(mode8) && $past(std625) == std625
    |-> $past(y_out[7]) && !$past(y_out[4]));
endmodule

// File: tb/vid_fmt422_tb.sv
`timescale 1ns/100ps
module vid_fmt422_tb_top;
  localparam int ACT = 8, HSW = 4;
  localparam int L6 = 40, L5 = 36, H6 = 16, H5 = 12;
  localparam int FA6 = 6, FB6 = 7, VB6 = 2, FA5 = 5, FB5 = 6, VB5 = 2;

  logic clk = 0, rst_n = 0, std625 = 1, mode8 = 0;
  logic [3:0] vp_x = 1, vp_w = 2, vp_y = 1, vp_h = 2;
  logic [7:0] bord_y = 8'h55, bord_u = 8'h66, bord_v = 8'h77;
  logic pix_valid = 1;
  logic [7:0] pix_y0 = 0, pix_y1 = 0, pix_u = 0, pix_v = 0;
  logic pix_ready, csync_n, href, vsync, cref;
  logic [7:0] y_out, uv_out;

  always #2.5 clk = ~clk;

  vid_fmt422 #(.ACT_PIX(ACT), .HSW(HSW), .LINE_625(L6), .LINE_525(L5),
    .HS_625(H6), .HS_525(H5), .FA_625(FA6), .FB_625(FB6), .VB_625(VB6),
    .FA_525(FA5), .FB_525(FB5), .VB_525(VB5), .XW(4), .YW(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .std625(std625), .mode8(mode8),
    .vp_x(vp_x), .vp_w(vp_w), .vp_y(vp_y), .vp_h(vp_h),
    .bord_y(bord_y), .bord_u(bord_u), .bord_v(bord_v),
    .pix_ready(pix_ready), .pix_valid(pix_valid), .pix_y0(pix_y0),
    .pix_y1(pix_y1), .pix_u(pix_u), .pix_v(pix_v), .csync_n(csync_n),
    .href(href), .vsync(vsync), .cref(cref), .y_out(y_out), .uv_out(uv_out));

  int checks = 0, errors = 0, cyc = 0, src = 0, gaps = 0;
  int h = 0, v = 0;
  logic [7:0] m_y0 = 16, m_y1 = 16, m_u = 128, m_v = 128;
  bit under = 0, done = 0;

  int e_L, e_fa, e_vb, e_hs, e_pos, e_ph, e_al;
  bit e_f, e_vbl, e_act, e_win, e_rdy, e_code;
  logic [7:0] e_y, e_uv, c_y0, c_y1, c_u, c_v;
  string dtag;

  task automatic chk(string req, string nm, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0h exp %0h", req, nm, got, exp);
    end
  endtask

  function automatic bit in_vp(int pos, int al_l);
    return pos >= 0 && pos < 2*ACT && e_vbl == 0 && al_l >= vp_y && al_l < vp_y + vp_h &&
           (pos/4) >= vp_x && (pos/4) < vp_x + vp_w;
  endfunction

  task automatic model_out();
    e_L  = std625 ? L6 : L5;
    e_fa = std625 ? FA6 : FA5;
    e_vb = std625 ? VB6 : VB5;
    e_hs = std625 ? H6 : H5;
    e_f  = (v >= e_fa);
    e_vbl = ((e_f ? v - e_fa : v) < e_vb);
    e_al = (e_f ? v - e_fa : v) - e_vb;
    e_pos = h - e_hs;
    e_ph = ((e_pos % 4) + 4) % 4;
    e_act = e_pos >= 0 && e_pos < 2*ACT;
    e_win = in_vp(e_pos, e_al);
    e_rdy = ((e_pos + 1) % 4 == 0) && in_vp(e_pos + 1, e_al);
    e_code = (e_pos >= -4 && e_pos < 0) || (e_pos >= 2*ACT && e_pos < 2*ACT + 4);
    if (e_win) begin
      c_y0 = m_y0; c_y1 = m_y1; c_u = m_u; c_v = m_v;
      dtag = under ? "R9" : (mode8 ? "R5" : "R4");
    end else if (e_act && !e_vbl) begin
      c_y0 = bord_y; c_y1 = bord_y; c_u = bord_u; c_v = bord_v; dtag = "R8";
    end else begin
      c_y0 = 16; c_y1 = 16; c_u = 128; c_v = 128; dtag = "R7";
    end
    if (mode8) begin
      e_uv = 0;
      if (e_code) begin
        bit hb = (e_pos >= 0);
        dtag = "R6";
        if (e_ph == 0) e_y = 8'hFF;
        else if (e_ph < 3) e_y = 0;
        else e_y = 8'(128 + e_f*64 + e_vbl*32 + hb*16 + (e_vbl ^ hb)*8 +
                      (e_f ^ hb)*4 + (e_f ^ e_vbl)*2 + (e_f ^ e_vbl ^ hb));
      end else
        e_y = (e_ph == 0) ? c_u : (e_ph == 1) ? c_y0 : (e_ph == 2) ? c_v : c_y1;
    end else begin
      e_y  = (e_ph < 2) ? c_y0 : c_y1;
      e_uv = (e_ph < 2) ? c_u : c_v;
    end
  endtask

  task automatic compare();
    string t;
    model_out();
    t = rst_n ? "" : "R11";
    chk(rst_n ? "R1" : t, "csync_n", csync_n, h >= HSW);
    chk(rst_n ? "R2" : t, "href", href, e_act && !e_vbl);
    chk(rst_n ? "R3" : t, "vsync", vsync, e_vbl);
    chk(rst_n ? "R4" : t, "cref", cref, (e_ph % 2) == 0);
    chk(rst_n ? "R8" : t, "pix_ready", pix_ready, e_rdy);
    chk(rst_n ? dtag : t, "y_out", y_out, e_y);
    chk(rst_n ? (mode8 ? "R5" : dtag) : t, "uv_out", uv_out, e_uv);
  endtask

  task automatic tick();
    cyc++;
    pix_valid = (gaps != 0 && cyc % 7 == 3) ? 1'b0 : 1'b1;
    pix_y0 = 8'(src * 4); pix_y1 = 8'(src * 4 + 1);
    pix_u = 8'(8'hA0 + src); pix_v = 8'(8'hC0 + src);
    if (rst_n) begin
      model_out();
      if (e_rdy) begin
        under = !pix_valid;
        if (pix_valid) begin
          m_y0 = pix_y0; m_y1 = pix_y1; m_u = pix_u; m_v = pix_v; src++;
        end else begin
          m_y0 = bord_y; m_y1 = bord_y; m_u = bord_u; m_v = bord_v;
        end
      end
      if (h >= e_L - 1) begin
        h = 0;
        v = (v >= (std625 ? FA6 + FB6 : FA5 + FB5) - 1) ? 0 : v + 1;
      end else h++;
    end
    @(negedge clk);
    compare();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    compare();                       // R11 reset state
    run(3);
    rst_n = 1;
    run(2 * L6 * (FA6 + FB6));       // R1 R2 R3 R4 R8 dual-bus, 625
    gaps = 1;
    run(L6 * (FA6 + FB6));           // R9 underruns
    mode8 = 1;
    run(L6 * (FA6 + FB6));           // R5 R6 single-bus
    while (!(h == 38 && v == 3)) tick();
    std625 = 0;
    tick();
    chk("R10", "csync_n after standard switch", csync_n, 0);
    run(2 * L5 * (FA5 + FB5));
    mode8 = 0; gaps = 0;
    vp_x = 0; vp_w = 4; vp_y = 0; vp_h = 4;
    run(L5 * (FA5 + FB5));           // R8 full viewport
    vp_w = 0;
    run(L5 * (FA5 + FB5));           // R8 empty viewport, border only
    std625 = 1; mode8 = 1; vp_w = 3; gaps = 1;
    run(L6 * (FA6 + FB6));           // R10 switch back
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule